// File: doc/BRIEF.md
# Sound Register Write Trap

This block watches the main CPU bus for writes that land in a sixteen-entry window of sound-register addresses, based at 0x4000 by default. When such a write occurs, the block captures the register index (the low four address bits) and the data byte. From the next cycle it holds the main CPU stalled through a halt output and raises a request to a sound-emulation coprocessor.

The coprocessor reads the captured index and data through its own read port, which uses a select input. It then acknowledges with a one-cycle strobe. The acknowledge drops the request, and the CPU is released on the following cycle. Because the CPU cannot run while a write is outstanding, a burst of consecutive sound writes reaches the coprocessor one at a time and in order.

An acknowledge may arrive in the same cycle as a new trapped write. In that case the new write is captured and the stall continues without a gap.

Top module: `snd_wr_trap`

## Requirements
- R1: After a synchronous active-high reset, `cop_req` and `cpu_halt` are 0, and the read port returns 0 for both select values.
- R2: A write (`cpu_we`=1) to any address from 0x4000 to 0x400F raises `cop_req` and `cpu_halt` from the next cycle on.
- R3: On a trapped write, the read port returns the index {4'b0, addr[3:0]} when `cop_rd_sel`=0 and the written data byte when `cop_rd_sel`=1.
- R4: Writes outside the window, including 0x4010 through 0x4015, 0x3FFF and 0x4020, raise neither output and leave the captured index and data unchanged.
- R5: A cycle with `cpu_we`=0 at a window address does not stall the CPU and leaves the captured index and data unchanged.
- R6: A one-cycle `cop_ack` pulse while a request is pending clears `cop_req`, and `cpu_halt` is 0 on the cycle after the pulse.
- R7: A trapped write in the same cycle as `cop_ack` is captured, and `cop_req` and `cpu_halt` stay 1.
- R8: A trapped write while a request is pending and no acknowledge is present is ignored: the captured values and the request are kept.
- R9: An acknowledge with no request pending has no effect on the outputs or the captured values.
- R10: `cpu_halt` is 1 exactly when `cop_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Main CPU address |
| cpu_wdata | input | 8 | Main CPU write data |
| cpu_we | input | 1 | Main CPU write strobe for this cycle |
| cpu_halt | output | 1 | Stall to the main CPU |
| cop_req | output | 1 | Pending-write request to the coprocessor |
| cop_rd_sel | input | 1 | Read select: 0 index, 1 data |
| cop_rd_data | output | 8 | Captured index or data |
| cop_ack | input | 1 | One-cycle acknowledge from the coprocessor |

## Verification
The request flag and the two captured fields are all the state this block has. A bad request flag therefore shows at both `cop_req` and `cpu_halt` one cycle after the write or acknowledge that should have moved it. A bad capture shows on `cop_rd_data` in that same cycle. The riskiest cases are a write that overwrites a pending one, which the coprocessor would see as the wrong index or data, and a missed re-trap in the acknowledge cycle, which would drop `cpu_halt` for one cycle. The bench drives each of these cases and reads the captured values back after every step.

// File: rtl/snd_trap_pkg.sv
package snd_trap_pkg;
  localparam int DEF_ADDR_W = 16;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_IDX_W  = 4;

  typedef enum logic {
    SEL_INDEX = 1'b0,
    SEL_DATA  = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/snd_win_decode.sv
module snd_win_decode #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              win_wr
);
  localparam int HI_W = ADDR_W - IDX_W;
  localparam logic [HI_W-1:0] BASE_HI = BASE[ADDR_W-1:IDX_W];

  function automatic logic in_win(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W] == BASE_HI;
  endfunction

  assign win_wr = we & in_win(addr);
endmodule

// File: rtl/snd_trap_ctrl.sv
module snd_trap_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic win_wr,
  input  logic cop_ack,
  output logic trap_accept,
  output logic req_q
);
  assign trap_accept = win_wr & (~req_q | cop_ack);

  always_ff @(posedge clk) begin
    if (rst)              req_q <= 1'b0;
    else if (trap_accept) req_q <= 1'b1;
    else if (cop_ack)     req_q <= 1'b0;
  end

  // R2
  trap_set_chk: assert property (@(posedge clk) disable iff (rst)
    trap_accept |=> req_q);
  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q && cop_ack && !win_wr) |=> !req_q);
  // R8
  hold_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q && !cop_ack) |=> req_q);
  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_q && !win_wr) |=> !req_q);
endmodule

// File: rtl/snd_trap_latch.sv
module snd_trap_latch #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  import snd_trap_pkg::*;
  localparam int PAD_W = DATA_W - IDX_W;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  function automatic logic [DATA_W-1:0] rd_pick(input logic sel,
                                                input logic [IDX_W-1:0] i,
                                                input logic [DATA_W-1:0] d);
    return (sel == SEL_DATA) ? d : {{PAD_W{1'b0}}, i};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      idx_q  <= idx_in;
      data_q <= data_in;
    end
  end

  assign rd_data = rd_pick(rd_sel, idx_q, data_q);

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (idx_q == $past(idx_in)) && (data_q == $past(data_in)));
  // R8
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(idx_q) && $stable(data_q));
endmodule

// File: rtl/snd_wr_trap.sv
module snd_wr_trap #(
  parameter int ADDR_W = snd_trap_pkg::DEF_ADDR_W,
  parameter int DATA_W = snd_trap_pkg::DEF_DATA_W,
  parameter int IDX_W  = snd_trap_pkg::DEF_IDX_W,
  parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic              cpu_halt,
  output logic              cop_req,
  input  logic              cop_rd_sel,
  output logic [DATA_W-1:0] cop_rd_data,
  input  logic              cop_ack
);
  localparam logic [ADDR_W-IDX_W-1:0] WIN_HI = BASE[ADDR_W-1:IDX_W];

  logic win_wr;
  logic trap_accept;
  logic req_q;

  snd_win_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_dec (
    .addr   (cpu_addr),
    .we     (cpu_we),
    .win_wr (win_wr)
  );

  snd_trap_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .win_wr      (win_wr),
    .cop_ack     (cop_ack),
    .trap_accept (trap_accept),
    .req_q       (req_q)
  );

  snd_trap_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_lat (
    .clk     (clk),
    .rst     (rst),
    .load    (trap_accept),
    .idx_in  (cpu_addr[IDX_W-1:0]),
    .data_in (cpu_wdata),
    .rd_sel  (cop_rd_sel),
    .rd_data (cop_rd_data)
  );

  assign cop_req  = req_q;
  assign cpu_halt = req_q;

  // R4
  outside_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cop_req && cpu_we && cpu_addr[ADDR_W-1:IDX_W] != WIN_HI) |=> !cop_req);
  // R5
  read_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cop_req && !cpu_we) |=> !cpu_halt);
  // R7
  ack_retrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cop_req && cop_ack && cpu_we && cpu_addr[ADDR_W-1:IDX_W] == WIN_HI)
      |=> (cop_req && cpu_halt));
endmodule

// File: tb/snd_wr_trap_tb.sv
`timescale 1ns/1ps
module snd_wr_trap_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_halt, cop_req;
  logic        cop_rd_sel = 1'b0;
  logic [7:0]  cop_rd_data;
  logic        cop_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] m_idx = '0;
  logic [7:0] m_dat = '0;

  always #2.5 clk = ~clk;

  snd_wr_trap u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_halt(cpu_halt), .cop_req(cop_req),
    .cop_rd_sel(cop_rd_sel), .cop_rd_data(cop_rd_data), .cop_ack(cop_ack)
  );

  // vector: {we, addr[15:0], data[7:0], expect_trap}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 16'h4000, 8'hA5, 1'b1},
    {1'b1, 16'h400F, 8'h3C, 1'b1},
    {1'b1, 16'h4010, 8'hFF, 1'b0},
    {1'b1, 16'h4015, 8'h11, 1'b0},
    {1'b0, 16'h4005, 8'h77, 1'b0},
    {1'b1, 16'h4007, 8'h81, 1'b1},
    {1'b1, 16'h3FFF, 8'h22, 1'b0},
    {1'b1, 16'h4020, 8'h33, 1'b0},
    {1'b1, 16'hC00A, 8'h44, 1'b0},
    {1'b1, 16'h400A, 8'h5E, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input logic exp, input string tag);
    chk(cop_req == exp, tag, 32'(cop_req), 32'(exp));
    chk(cpu_halt == exp, tag, 32'(cpu_halt), 32'(exp));
  endtask

  task automatic chk_read(input string tag);
    cop_rd_sel = 1'b0; #0.5;
    chk(cop_rd_data == {4'b0, m_idx}, tag, 32'(cop_rd_data), 32'({4'b0, m_idx}));
    cop_rd_sel = 1'b1; #0.5;
    chk(cop_rd_data == m_dat, tag, 32'(cop_rd_data), 32'(m_dat));
    cop_rd_sel = 1'b0;
  endtask

  task automatic bus_cycle(input logic we, input logic [15:0] a,
                           input logic [7:0] d, input logic ack);
    cpu_we = we; cpu_addr = a; cpu_wdata = d; cop_ack = ack;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0; cop_ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_flags(1'b0, "R1 reset flags");
    chk_read("R1 reset read");

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VEC[i][25], VEC[i][24:9], VEC[i][8:1], 1'b0);
      if (VEC[i][0]) begin
        m_idx = VEC[i][12:9];
        m_dat = VEC[i][8:1];
        chk_flags(1'b1, "R2 trapped write");
        chk_read("R3 captured values");
        chk(cpu_halt == cop_req, "R10 halt follows req", 32'(cpu_halt), 32'(cop_req));
        bus_cycle(1'b0, 16'h0000, 8'h00, 1'b1);
        chk_flags(1'b0, "R6 ack release");
      end else begin
        chk_flags(1'b0, VEC[i][25] ? "R4 outside window" : "R5 read no stall");
        chk_read(VEC[i][25] ? "R4 latch kept" : "R5 latch kept");
      end
    end

    // R8: second write while pending without ack
    bus_cycle(1'b1, 16'h4002, 8'h12, 1'b0);
    m_idx = 4'h2; m_dat = 8'h12;
    bus_cycle(1'b1, 16'h4009, 8'h99, 1'b0);
    chk_flags(1'b1, "R8 still pending");
    chk_read("R8 pending write ignored");

    // R7: new write in ack cycle
    bus_cycle(1'b1, 16'h4003, 8'hC7, 1'b1);
    m_idx = 4'h3; m_dat = 8'hC7;
    chk_flags(1'b1, "R7 retrap on ack");
    chk_read("R7 new values");
    bus_cycle(1'b0, 16'h0000, 8'h00, 1'b1);
    chk_flags(1'b0, "R6 release after retrap");

    // R9: ack while idle
    bus_cycle(1'b0, 16'h4001, 8'h00, 1'b1);
    chk_flags(1'b0, "R9 idle ack");
    chk_read("R9 idle ack latch kept");

    // R1: reset while pending
    bus_cycle(1'b1, 16'h400E, 8'h6B, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_idx = '0; m_dat = '0;
    chk_flags(1'b0, "R1 reset while pending");
    chk_read("R1 reset clears latch");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule